// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable model of a serial EEPROM seen from the device side. A host drives chip select, a shift clock and a serial data line. The block answers on a data-out line that it can release. A strap input selects the word size. When the strap is high the array holds 256 words of 16 bits. When it is low the same storage is seen as 512 bytes. A free-running system clock samples all serial pins through two-flop synchronizers, and rising shift-clock edges are detected in that clock domain.

Each command begins with a logic 1 start bit, captured on a rising shift-clock edge while chip select is high. A 2-bit opcode follows, then the address bits. Opcode `10` reads, `01` writes, `11` erases one location, and `00` takes its real meaning from the two top address bits. For opcode `00`, `11` enables programming, `00` disables it, `10` fills the array with ones and `01` writes one data word to every location. Programming commands start a self-timed busy period of `WP_CYCLES` system clocks. During that period the host can poll ready/busy on the data-out line.

The controller has seven states. **S_IDLE** is entered whenever chip select is low. On chip select rising it goes to **S_HUNT** if the block is idle. If a program cycle is running, it goes to **S_STATUS** when chip select was low for at least `TCS_MIN` clocks, and to **S_HOLD** otherwise. **S_HUNT** moves to **S_CMD** on a start bit. **S_CMD** shifts opcode and address and then decodes. A read goes to **S_READ**. A write or write-all with programming enabled goes to **S_DATA**. Every other command goes to **S_HOLD**. **S_DATA** collects the data word, fires the program and goes to **S_HOLD**. **S_READ**, **S_STATUS** and **S_HOLD** stay where they are until chip select drops.

Top module: `tw_eeprom`

## Requirements
- R1: After reset `dout_oe` is 0 and programming is disabled, so a WRITE or ERASE sent before any enable command leaves the array unchanged.
- R2: Zeros clocked in on `di` before the start bit are ignored. The command frame begins at the first 1 sampled on a rising `sk` edge while `cs` is high.
- R3: A READ first drives one 0 dummy bit after the last address bit. The word follows most significant bit first, and each bit is advanced by a rising `sk` edge.
- R4: While `cs` stays high after a word, reading continues at the next address with no dummy bit. The address wraps from the top location (255 wide, 511 narrow) to 0.
- R5: With programming enabled, WRITE (opcode `01`) stores the data word at the given address.
- R6: After EWDS (opcode `00`, sub-code `00`), WRITE, ERASE, ERAL and WRAL have no effect. READ still works, and EWEN (sub-code `11`) enables programming again.
- R7: ERASE (opcode `11`) sets every bit of the addressed location to 1 and leaves the other locations unchanged.
- R8: ERAL (sub-code `10`) sets every location to all ones. WRAL (sub-code `01`) writes its data word to every location.
- R9: If `cs` is raised during a program cycle after at least `TCS_MIN` low clocks, `dout` drives 0 while busy and 1 once the cycle ends.
- R10: No status is driven (`dout_oe` stays 0) when `cs` is raised after the program cycle has ended, or when the preceding low time was shorter than `TCS_MIN`.
- R11: `dout_oe` is 0 while `cs` is low, and lowering `cs` discards a partly received command.
- R12: A command sent while a program cycle is running has no effect.
- R13: With `org_wide` low, addresses are 9 bits and data is 8 bits. Byte address b lives in word b>>1, in the low half when b is even and the high half when b is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset; the array keeps its contents |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock |
| di | input | 1 | Serial data in |
| org_wide | input | 1 | 1: 16-bit words, 8 address bits; 0: 8-bit words, 9 address bits |
| dout | output | 1 | Serial data / ready-busy value |
| dout_oe | output | 1 | Output enable for `dout`; 0 means released (high impedance) |

## Verification
A wrong opcode or sub-code decode shows at the next read, as a location that changed or failed to change. The bench reads back the addressed location and at least one neighbour after every programming command. A stale enable flag or busy timer shows as a write that was accepted when it should have been refused, or the reverse. It also shows as `dout_oe` going high when `cs` rises, about three system clocks after the pin changes. Read-pointer or bit-index errors show within one word as a missing dummy bit, a shifted pattern or a wrong wrap target, because each read is compared bit by bit right after the last address bit.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;
    localparam int unsigned NUM_WORDS = 256;
    localparam int unsigned WORD_W    = 16;
    localparam int unsigned ADDR_W    = 9;   // byte-address width in narrow mode

    typedef enum logic [2:0] {
        S_IDLE, S_HUNT, S_CMD, S_DATA, S_READ, S_STATUS, S_HOLD
    } state_t;

    typedef enum logic [1:0] {
        OP_SPECIAL = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b10,
        OP_ERASE   = 2'b11
    } op_t;

    typedef enum logic [1:0] {
        SUB_LOCK   = 2'b00,
        SUB_FILL   = 2'b01,
        SUB_WIPE   = 2'b10,
        SUB_UNLOCK = 2'b11
    } sub_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/tw_timers.sv
module tw_timers #(
    parameter int unsigned WP_CYCLES = 625000,
    parameter int unsigned TCS_MIN   = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic start,
    output logic busy,
    output logic gap_ok
);
    localparam int unsigned WPW = $clog2(WP_CYCLES + 1);
    localparam int unsigned TCW = $clog2(TCS_MIN + 1);

    logic [WPW-1:0] wp_cnt;
    logic [TCW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_cnt  <= '0;
            low_cnt <= '0;
        end else begin
            if (start)
                wp_cnt <= WPW'(WP_CYCLES);
            else if (wp_cnt != '0)
                wp_cnt <= wp_cnt - 1'b1;

            if (cs_s)
                low_cnt <= '0;
            else if (low_cnt != TCW'(TCS_MIN))
                low_cnt <= low_cnt + 1'b1;
        end
    end

    assign busy   = (wp_cnt != '0);
    assign gap_ok = (low_cnt == TCW'(TCS_MIN));
endmodule

// File: rtl/tw_array.sv
module tw_array #(
    parameter int unsigned WORDS = 256,
    parameter int unsigned DW    = 16,
    parameter int unsigned AW    = 9
) (
    input  logic          clk,
    input  logic          org_wide,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_one,
    input  logic          wr_all,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    localparam int unsigned HW = DW / 2;
    localparam int unsigned IW = $clog2(WORDS);

    logic [DW-1:0] mem [WORDS];
    logic [IW-1:0] rd_idx, wr_idx;
    logic [DW-1:0] rd_word;

    assign rd_idx  = org_wide ? rd_addr[IW-1:0] : rd_addr[AW-1:1];
    assign wr_idx  = org_wide ? wr_addr[IW-1:0] : wr_addr[AW-1:1];
    assign rd_word = mem[rd_idx];

    always_comb begin
        if (org_wide)
            rd_data = rd_word;
        else if (rd_addr[0])
            rd_data = {{HW{1'b0}}, rd_word[DW-1:HW]};
        else
            rd_data = {{HW{1'b0}}, rd_word[HW-1:0]};
    end

    always_ff @(posedge clk) begin
        if (wr_all) begin
            for (int i = 0; i < int'(WORDS); i++)
                mem[i] <= org_wide ? wr_data : {wr_data[HW-1:0], wr_data[HW-1:0]};
        end else if (wr_one) begin
            if (org_wide)
                mem[wr_idx] <= wr_data;
            else if (wr_addr[0])
                mem[wr_idx][DW-1:HW] <= wr_data[HW-1:0];
            else
                mem[wr_idx][HW-1:0] <= wr_data[HW-1:0];
        end
    end
endmodule

// File: rtl/tw_eeprom.sv
module tw_eeprom
    import tw_eeprom_pkg::*;
#(
    parameter int unsigned WP_CYCLES = 625000,
    parameter int unsigned TCS_MIN   = 32,
    parameter int unsigned WORDS     = NUM_WORDS,
    parameter int unsigned DW        = WORD_W,
    parameter int unsigned AW        = ADDR_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic org_wide,
    output logic dout,
    output logic dout_oe
);
    localparam int unsigned CW   = AW + 2;
    localparam int unsigned MAXB = (CW > DW) ? CW : DW;
    localparam int unsigned BCW  = $clog2(MAXB + 1);
    localparam int unsigned SW   = $clog2(DW);

    logic cs_s, sk_s, di_s, org_s, sk_d, sk_rise;
    logic busy, gap_ok;
    state_t state, nxt;

    logic [CW-1:0]  sh;
    logic [DW-1:0]  dat;
    logic [BCW-1:0] cnt, rd_left, cmd_len, data_len;
    logic [AW-1:0]  addr_q, addr_f, nxt_addr, rd_a, wr_addr;
    logic [DW-1:0]  rd_data, wr_data;
    logic [SW-1:0]  bit_sel;
    op_t            op_f, op_q;
    sub_t           sub_f;
    logic           do_q, wen_q;
    logic           cmd_done, dat_done, cmd_fire, dat_fire;
    logic           arr_wr_one, arr_wr_all, st_read;

    tw_sync #(.W(4)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs, sk, di, org_wide}),
        .q({cs_s, sk_s, di_s, org_s})
    );

    tw_timers #(.WP_CYCLES(WP_CYCLES), .TCS_MIN(TCS_MIN)) u_timers (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s),
        .start(arr_wr_one | arr_wr_all),
        .busy(busy), .gap_ok(gap_ok)
    );

    tw_array #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_array (
        .clk(clk), .org_wide(org_s),
        .rd_addr(rd_a), .rd_data(rd_data),
        .wr_one(arr_wr_one), .wr_all(arr_wr_all),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Frame decode: the field positions move by one bit with the organization
    assign sk_rise  = sk_s & ~sk_d;
    assign cmd_len  = org_s ? BCW'(CW - 1) : BCW'(CW);
    assign data_len = org_s ? BCW'(DW) : BCW'(DW / 2);
    assign op_f     = op_t'(org_s ? sh[CW-2:CW-3] : sh[CW-1:CW-2]);
    assign sub_f    = sub_t'(org_s ? sh[AW-2:AW-3] : sh[AW-1:AW-2]);
    assign addr_f   = org_s ? {1'b0, sh[AW-2:0]} : sh[AW-1:0];
    assign cmd_done = (cnt == cmd_len);
    assign dat_done = (cnt == data_len);
    assign cmd_fire = cs_s && (state == S_CMD) && cmd_done;
    assign dat_fire = cs_s && (state == S_DATA) && dat_done;

    assign arr_wr_one = wen_q && ((cmd_fire && op_f == OP_ERASE) ||
                                  (dat_fire && op_q == OP_WRITE));
    assign arr_wr_all = wen_q && ((cmd_fire && op_f == OP_SPECIAL && sub_f == SUB_WIPE) ||
                                  (dat_fire && op_q == OP_SPECIAL));
    assign wr_addr    = (state == S_CMD) ? addr_f : addr_q;
    assign wr_data    = (state == S_CMD) ? '1 : dat;

    // Sequential read pointer: rd_left == 0 means the next edge opens a new word
    assign nxt_addr = org_s ? {1'b0, addr_q[AW-2:0] + 1'b1} : addr_q + 1'b1;
    assign rd_a     = (rd_left == '0) ? nxt_addr : addr_q;
    assign bit_sel  = (rd_left == '0) ? SW'(data_len - 1'b1) : SW'(rd_left - 1'b1);
    assign st_read  = (state == S_READ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   nxt = busy ? (gap_ok ? S_STATUS : S_HOLD) : S_HUNT;
            S_HUNT:   if (sk_rise && di_s) nxt = S_CMD;
            S_CMD: begin
                if (cmd_done) begin
                    if (op_f == OP_READ)
                        nxt = S_READ;
                    else if (wen_q && (op_f == OP_WRITE ||
                             (op_f == OP_SPECIAL && sub_f == SUB_FILL)))
                        nxt = S_DATA;
                    else
                        nxt = S_HOLD;
                end
            end
            S_DATA:   if (dat_done) nxt = S_HOLD;
            S_READ, S_STATUS, S_HOLD: nxt = state;
            default:  nxt = S_IDLE;
        endcase
        if (!cs_s) nxt = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_d    <= 1'b0;
            sh      <= '0;
            dat     <= '0;
            cnt     <= '0;
            rd_left <= '0;
            addr_q  <= '0;
            op_q    <= OP_SPECIAL;
            do_q    <= 1'b0;
            wen_q   <= 1'b0;
        end else begin
            sk_d <= sk_s;
            if (cmd_fire && op_f == OP_SPECIAL) begin
                if (sub_f == SUB_UNLOCK)    wen_q <= 1'b1;
                else if (sub_f == SUB_LOCK) wen_q <= 1'b0;
            end
            unique case (state)
                S_HUNT: begin
                    cnt <= '0;
                    sh  <= '0;
                    dat <= '0;
                end
                S_CMD: begin
                    if (cmd_done) begin
                        op_q    <= op_f;
                        addr_q  <= addr_f;
                        cnt     <= '0;
                        do_q    <= 1'b0;
                        rd_left <= data_len;
                    end else if (sk_rise) begin
                        sh  <= {sh[CW-2:0], di_s};
                        cnt <= cnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (sk_rise && !dat_done) begin
                        dat <= {dat[DW-2:0], di_s};
                        cnt <= cnt + 1'b1;
                    end
                end
                S_READ: begin
                    if (sk_rise) begin
                        do_q <= rd_data[bit_sel];
                        if (rd_left == '0) begin
                            addr_q  <= nxt_addr;
                            rd_left <= data_len - 1'b1;
                        end else begin
                            rd_left <= rd_left - 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        dout_oe = 1'b0;
        dout    = 1'b0;
        unique case (state)
            S_READ: begin
                dout_oe = 1'b1;
                dout    = do_q;
            end
            S_STATUS: begin
                dout_oe = 1'b1;
                dout    = ~busy;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tw_eeprom_chk.sv
module tw_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic dout,
    input logic dout_oe,
    input logic busy,
    input logic wr_one,
    input logic wr_all,
    input logic wen,
    input logic in_read
);
    AST_OE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs && !$past(cs) && !$past(cs, 2) && !$past(cs, 3)) |-> !dout_oe); // R11

    AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_read) |-> (dout_oe && !dout)); // R3

    AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_one || wr_all) |-> wen); // R6

    AST_NO_PROG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(wr_one || wr_all)); // R12

    AST_ONE_PROG_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_one, wr_all})); // R8

    AST_BUSY_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_one || wr_all) |=> busy); // R9
endmodule

bind tw_eeprom tw_eeprom_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .dout(dout), .dout_oe(dout_oe),
    .busy(busy), .wr_one(arr_wr_one), .wr_all(arr_wr_all),
    .wen(wen_q), .in_read(st_read)
);

// File: tb/tw_eeprom_tb.sv
module tw_eeprom_tb;
    localparam int WP  = 300;
    localparam int TCS = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, org_wide = 1'b1;
    logic dout, dout_oe;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tw_eeprom #(.WP_CYCLES(WP), .TCS_MIN(TCS)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .org_wide(org_wide), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sk_bit(input logic b);
        di = b;
        wait_clk(4);
        sk = 1'b1;
        wait_clk(8);
        sk = 1'b0;
        wait_clk(4);
    endtask

    task automatic sel();
        cs = 1'b1;
        wait_clk(4);
    endtask

    task automatic desel(input int n);
        cs = 1'b0;
        di = 1'b0;
        wait_clk(n);
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [8:0] a);
        sel();
        sk_bit(1'b1);
        sk_bit(op[1]);
        sk_bit(op[0]);
        for (int i = (org_wide ? 7 : 8); i >= 0; i--) sk_bit(a[i]);
    endtask

    task automatic send_data(input logic [15:0] d);
        for (int i = (org_wide ? 15 : 7); i >= 0; i--) sk_bit(d[i]);
    endtask

    function automatic logic [8:0] sub_addr(input logic [1:0] sub);
        return org_wide ? {1'b0, sub, 6'b0} : {sub, 7'b0};
    endfunction

    // Programming commands: chip select then stays low past the whole cycle
    task automatic cmd_special(input logic [1:0] sub, input logic [15:0] d);
        send_cmd(2'b00, sub_addr(sub));
        if (sub == 2'b01) send_data(d);
        desel(WP + 40);
    endtask

    task automatic cmd_write(input logic [8:0] a, input logic [15:0] d);
        send_cmd(2'b01, a);
        send_data(d);
        desel(WP + 40);
    endtask

    task automatic cmd_erase(input logic [8:0] a);
        send_cmd(2'b11, a);
        desel(WP + 40);
    endtask

    task automatic read_bits(input int n, output logic [31:0] w);
        w = '0;
        for (int i = 0; i < n; i++) begin
            sk_bit(1'b0);
            w = {w[30:0], dout};
        end
    endtask

    task automatic cmd_read(input string req, input logic [8:0] a, input int words,
                            input logic [31:0] exp);
        logic [31:0] w;
        send_cmd(2'b10, a);
        check({req, " dummy bit (R3)"}, {30'b0, dout_oe, dout}, 32'h2);
        read_bits(words * (org_wide ? 16 : 8), w);
        check(req, w, exp);
        desel(10);
    endtask

    task automatic t_reset_lock();
        cmd_special(2'b11, 16'h0);
        cmd_special(2'b01, 16'hA5A5);
        rst_n = 1'b0;
        wait_clk(3);
        check("R1 oe in reset", {31'b0, dout_oe}, 32'h0);
        rst_n = 1'b1;
        wait_clk(3);
        cmd_write(9'd5, 16'h1234);
        cmd_erase(9'd6);
        cmd_read("R1 write after reset ignored", 9'd5, 1, 32'hA5A5);
        cmd_read("R1 erase after reset ignored", 9'd6, 1, 32'hA5A5);
    endtask

    task automatic t_write_read();
        cmd_special(2'b11, 16'h0);
        sel();
        sk_bit(1'b0); sk_bit(1'b0); sk_bit(1'b0);     // R2 preamble zeros
        sk_bit(1'b1); sk_bit(1'b0); sk_bit(1'b1);
        for (int i = 7; i >= 0; i--) sk_bit(i == 0 || i == 1);
        send_data(16'hBEEF);
        desel(WP + 40);
        cmd_write(9'd4, 16'h8001);
        cmd_read("R2 R5 word 3", 9'd3, 1, 32'hBEEF);
        cmd_read("R3 R5 word 4", 9'd4, 1, 32'h8001);
    endtask

    task automatic t_erase_all();
        cmd_erase(9'd3);
        cmd_read("R7 erased word", 9'd3, 1, 32'hFFFF);
        cmd_read("R7 neighbour kept", 9'd4, 1, 32'h8001);
        cmd_special(2'b10, 16'h0);
        cmd_read("R8 ERAL", 9'd4, 1, 32'hFFFF);
        cmd_special(2'b01, 16'h1357);
        cmd_read("R8 WRAL", 9'd200, 1, 32'h1357);
    endtask

    task automatic t_lock();
        cmd_special(2'b00, 16'h0);
        cmd_write(9'd10, 16'h0000);
        cmd_special(2'b10, 16'h0);
        cmd_read("R6 locked write/ERAL ignored", 9'd10, 1, 32'h1357);
        cmd_special(2'b11, 16'h0);
        cmd_write(9'd10, 16'h0A0A);
        cmd_read("R6 re-enabled write", 9'd10, 1, 32'h0A0A);
    endtask

    task automatic t_seq();
        cmd_write(9'd255, 16'h0F0F);
        cmd_write(9'd0, 16'hF0F0);
        cmd_read("R4 wrap 255->0", 9'd255, 2, 32'h0F0FF0F0);
    endtask

    task automatic t_status();
        send_cmd(2'b01, 9'd20);
        send_data(16'h2222);
        desel(40);
        sel();
        wait_clk(6);
        check("R9 busy status", {30'b0, dout_oe, dout}, 32'h2);
        wait_clk(WP);
        check("R9 ready status", {30'b0, dout_oe, dout}, 32'h3);
        desel(10);
        cmd_read("R9 status write stored", 9'd20, 1, 32'h2222);
    endtask

    task automatic t_no_status();
        send_cmd(2'b01, 9'd21);
        send_data(16'h3333);
        desel(WP + 60);
        sel();
        wait_clk(8);
        check("R10 no status after cycle", {31'b0, dout_oe}, 32'h0);
        desel(10);
        send_cmd(2'b01, 9'd22);
        send_data(16'h4444);
        desel(8);
        sel();
        wait_clk(8);
        check("R10 no status on short gap", {31'b0, dout_oe}, 32'h0);
        sk_bit(1'b1); sk_bit(1'b0); sk_bit(1'b1);     // R12 write during busy
        for (int i = 7; i >= 0; i--) sk_bit(i == 0 || i == 2 || i == 4);
        send_data(16'h9999);
        desel(WP + 40);
        cmd_read("R12 busy command ignored", 9'd21, 1, 32'h3333);
        cmd_read("R10 first write kept", 9'd22, 1, 32'h4444);
    endtask

    task automatic t_abort();
        sel();
        sk_bit(1'b1); sk_bit(1'b1); sk_bit(1'b0); sk_bit(1'b1); sk_bit(1'b0);
        desel(10);
        check("R11 oe low with cs low", {31'b0, dout_oe}, 32'h0);
        cmd_read("R11 after abort", 9'd22, 1, 32'h4444);
        send_cmd(2'b10, 9'd20);
        sk_bit(1'b0);
        desel(6);
        check("R11 read released on cs low", {31'b0, dout_oe}, 32'h0);
        desel(10);
    endtask

    task automatic t_byte();
        org_wide = 1'b0;
        wait_clk(6);
        cmd_special(2'b10, 16'h0);
        cmd_write(9'd6, 16'h003C);
        cmd_write(9'd7, 16'h00C3);
        cmd_read("R13 byte 6", 9'd6, 1, 32'h3C);
        cmd_read("R13 byte 7", 9'd7, 1, 32'hC3);
        org_wide = 1'b1;
        wait_clk(6);
        cmd_read("R13 lanes in word 3", 9'd3, 1, 32'hC33C);
        org_wide = 1'b0;
        wait_clk(6);
        cmd_write(9'd0, 16'h005A);
        cmd_write(9'd511, 16'h00A5);
        cmd_read("R4 R13 wrap 511->0", 9'd511, 2, 32'hA55A);
        org_wide = 1'b1;
    endtask

    initial begin
        wait_clk(10);
        check("R1 oe after reset", {31'b0, dout_oe}, 32'h0);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset_lock();
        t_write_read();
        t_erase_all();
        t_lock();
        t_seq();
        t_status();
        t_no_status();
        t_abort();
        t_byte();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule